// File: doc/BRIEF.md
# Binary FSK Tone Synthesizer

This block produces the digital sine samples for a binary frequency-shift-keyed transmitter using direct digital synthesis clocked by a 16 MHz reference. The host selects one of eight carriers, one of four symbol rates and a deviation factor of one or one half. The block then derives two tones that sit half a deviation above and below the carrier. The data bit picks the upper tone for a 0 and the lower tone for a 1. A tone switch is deferred until the sine wave in progress finishes its current half cycle, so the waveform never jumps in phase.

Two host modes exist. In the direct mode the transmit data pin steers the tone selection immediately. In the clocked mode the block generates its own bit clock at the selected symbol rate and latches the data pin on each rising edge of that clock. The clocked mode can optionally hold its first bit clock edge back until the mains voltage makes its first positive zero crossing.

Samples leave on a valid/ready stream toward a DAC. `sample_valid` is high for as long as transmission is enabled. A sample is consumed when `sample_valid` and `sample_ready` are both high. While `sample_ready` is low, the sample is held unchanged and the phase does not advance. The sink therefore sets the sample rate, and the synthesized frequency is referred to accepted samples.

Top module: `fsk_dds_mod`

## Requirements
- R1: While `tx_en` is low, and in the cycle after it is seen low, `sample_valid` is 0, `sample_data` is 0, `clr_t` is 0 and the 24-bit phase is 0. The same values apply after reset.
- R2: Each accepted sample (valid and ready high at a clock edge) adds the active tuning word to the phase, modulo 2^24. When `sample_ready` is low, the phase and `sample_data` stay constant.
- R3: Carrier code `chan_sel` 0..7 selects 60000, 66000, 72000, 76000, 82050, 86000, 110000 or 132500 Hz. Baud code `baud_sel` 0..3 selects 600, 1200, 2400 or 4800 baud. The tuning word is round(Fc*2^24/16e6) plus, for tone bit 0, or minus, for tone bit 1, round(Fh*2^24/16e6), where Fh is half the deviation.
- R4: With `dev_sel`=1 (factor 1), Fh is baud/2. With `dev_sel`=0 (factor 0.5), Fh is baud/4. The disallowed pair of 600 baud with factor 0.5 is treated as factor 1.
- R5: During transmission, the active tuning word takes the newly selected value only at an accepted sample whose addition changes phase bit 23. At every other edge it is unchanged. While idle, it is loaded with the selected value on every cycle.
- R6: `sample_data` is a signed function of the phase. Phase bit 23 gives the sign (1 = negative), and bit 22 selects the mirrored quarter. Let f be bits 21:16, and let i = f when bit 22 is 0, or 64-f when it is 1. The magnitude is floor(4*511*p/(20480-p)) with p = i*(128-i).
- R7: When `sync_mode` is 0, the tone bit is the current `txd` level, and `clr_t` stays 0.
- R8: When `sync_mode` is 1, the bit clock period is P = round(16e6/baud) cycles. The counter starts at 0 in the running state and wraps after P-1. `clr_t` is high when the count is at least floor(P/2). `txd` is latched at the edge where `clr_t` rises. The latched bit is 1 until the first latch.
- R9: When `sync_mode` and `zc_sync_en` are both 1, starting a transmission enters a wait state in which `clr_t` stays 0. The counter starts from 0 at the first edge where `zc_in` is 1 and was 0 in the previous cycle. Later crossings have no effect.
- R10: At the first edge where `tx_en` is high, `sample_valid` rises with the phase at 0, so the first offered sample is 0.
- R11: A drop of `tx_en` returns the block to the idle state of R1 at the next edge, and the next start begins a fresh bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz synthesis reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmission enable |
| sync_mode | input | 1 | 1 = clocked host mode, 0 = direct mode |
| zc_sync_en | input | 1 | Hold first bit clock edge for a mains zero crossing |
| chan_sel | input | 3 | Carrier code |
| baud_sel | input | 2 | Symbol rate code |
| dev_sel | input | 1 | 1 = deviation factor 1, 0 = factor 0.5 |
| txd | input | 1 | Transmit data bit |
| zc_in | input | 1 | Mains polarity (1 = positive half wave) |
| clr_t | output | 1 | Generated bit clock in clocked mode |
| sample_data | output | 10 | Signed sine sample |
| sample_valid | output | 1 | Sample stream valid |
| sample_ready | input | 1 | Sample stream ready from the DAC side |

## Verification
Every registered result is due one edge after the stimulus that causes it. `sample_valid` follows `tx_en` at the next edge, and a consumed sample moves the phase, and so `sample_data`, at that same edge. A tone change appears only at the edge that carries the phase across a half cycle. `clr_t` rises floor(P/2) edges after the running state begins. The bench keeps a cycle model that steps at each rising edge from the inputs that were applied mid-cycle. It compares the model with the outputs at the falling edge, so each check lands exactly in the cycle where the requirement says the change is visible.

// File: rtl/fsk_dds_pkg.sv
`timescale 1ns/1ps
package fsk_dds_pkg;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_WAIT = 2'd1,
    T_RUN  = 2'd2
  } tmr_state_e;

  // Rounded phase increment for a tone of hz at the reference clock.
  function automatic longint unsigned tw_of(input longint unsigned hz,
                                            input int acc_w,
                                            input longint unsigned clk_hz);
    return ((hz << acc_w) + clk_hz / 2) / clk_hz;
  endfunction

  // Carrier frequency per channel code; the code order is the selection map.
  function automatic longint unsigned car_hz(input int unsigned code);
    case (code)
      0: return 60000;
      1: return 66000;
      2: return 72000;
      3: return 76000;
      4: return 82050;
      5: return 86000;
      6: return 110000;
      default: return 132500;
    endcase
  endfunction

  // Half deviation for index {baud code, deviation bit}.
  function automatic longint unsigned half_dev_hz(input int unsigned idx);
    longint unsigned baud;
    baud = longint'(600) << (idx >> 1);
    if ((idx & 1) == 0 && baud != 600) return baud / 4;
    return baud / 2;
  endfunction

  // Bit period in reference cycles, rounded.
  function automatic int unsigned per_of(input longint unsigned clk_hz,
                                         input longint unsigned baud);
    return int'((clk_hz + baud / 2) / baud);
  endfunction

  // Quarter-wave magnitude by a rational sine approximation.
  function automatic int unsigned sine_pt(input int unsigned k,
                                          input int unsigned q,
                                          input int unsigned amp);
    longint unsigned p;
    longint unsigned num;
    longint unsigned den;
    p   = longint'(k) * longint'(2 * q - k);
    num = 4 * longint'(amp) * p;
    den = 5 * longint'(q) * longint'(q) - p;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/fsk_tune_sel.sv
`timescale 1ns/1ps
module fsk_tune_sel
  import fsk_dds_pkg::*;
#(
  parameter int              ACC_W  = 24,
  parameter longint unsigned CLK_HZ = 16_000_000
) (
  input  logic [2:0]       chan_sel,
  input  logic [1:0]       baud_sel,
  input  logic             dev_sel,
  input  logic             tone_bit,
  output logic [ACC_W-1:0] tw_pend
);
  localparam int N_CAR = 8;
  localparam int N_HD  = 8;

  logic [ACC_W-1:0] car_lut [N_CAR];
  logic [ACC_W-1:0] hd_lut  [N_HD];
  logic [ACC_W-1:0] car_w;
  logic [ACC_W-1:0] hd_w;

  // Carrier increments, one per channel code.
  for (genvar c = 0; c < N_CAR; c++) begin : g_car
    localparam longint unsigned TW = tw_of(car_hz(c), ACC_W, CLK_HZ);
    assign car_lut[c] = ACC_W'(TW);
  end

  // Half-deviation increments, indexed by {baud code, deviation bit}.
  for (genvar h = 0; h < N_HD; h++) begin : g_hd
    localparam longint unsigned TW = tw_of(half_dev_hz(h), ACC_W, CLK_HZ);
    assign hd_lut[h] = ACC_W'(TW);
  end

  assign car_w = car_lut[chan_sel];
  assign hd_w  = hd_lut[{baud_sel, dev_sel}];

  // Bit 0 -> upper tone, bit 1 -> lower tone.
  assign tw_pend = tone_bit ? (car_w - hd_w) : (car_w + hd_w);

endmodule

// File: rtl/fsk_bit_timer.sv
`timescale 1ns/1ps
module fsk_bit_timer
  import fsk_dds_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 16_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       sync_mode,
  input  logic       zc_sync_en,
  input  logic [1:0] baud_sel,
  input  logic       txd,
  input  logic       zc_in,
  output logic       clr_t,
  output logic       tone_bit
);
  localparam int unsigned P_MAX = per_of(CLK_HZ, 600);
  localparam int          CNT_W = $clog2(P_MAX + 1);

  logic [CNT_W-1:0] per_lut [4];
  logic [CNT_W-1:0] per_w;
  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] cnt_q;
  logic             bit_q;
  logic             zc_prev_q;
  logic             zc_rise;
  tmr_state_e       st_q;

  for (genvar b = 0; b < 4; b++) begin : g_per
    localparam int unsigned P = per_of(CLK_HZ, 600 << b);
    assign per_lut[b] = CNT_W'(P);
  end

  assign per_w   = per_lut[baud_sel];
  assign half_w  = per_w >> 1;
  assign zc_rise = zc_in & ~zc_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= T_IDLE;
      cnt_q     <= '0;
      bit_q     <= 1'b1;
      zc_prev_q <= 1'b1;
    end else begin
      zc_prev_q <= zc_in;
      if (!tx_en) begin
        st_q  <= T_IDLE;
        cnt_q <= '0;
        bit_q <= 1'b1;
      end else begin
        case (st_q)
          T_IDLE: begin
            st_q  <= (sync_mode && zc_sync_en) ? T_WAIT : T_RUN;
            cnt_q <= '0;
          end
          T_WAIT: begin
            if (zc_rise) st_q <= T_RUN;
          end
          T_RUN: begin
            if (sync_mode && cnt_q == half_w - CNT_W'(1)) bit_q <= txd;
            cnt_q <= (cnt_q >= per_w - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
          end
          default: st_q <= T_IDLE;
        endcase
      end
    end
  end

  assign clr_t    = (st_q == T_RUN) && sync_mode && (cnt_q >= half_w);
  assign tone_bit = sync_mode ? bit_q : txd;

  // R8: an idle transmitter latches the mark bit.
  p_idle_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> bit_q);

  // R9: without a positive crossing the wait state persists.
  p_wait_zc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == T_WAIT) && tx_en && !zc_rise |=> (st_q == T_WAIT) && !clr_t);

endmodule

// File: rtl/fsk_dds_core.sv
`timescale 1ns/1ps
module fsk_dds_core
  import fsk_dds_pkg::*;
#(
  parameter int ACC_W  = 24,
  parameter int SAMP_W = 10,
  parameter int QB     = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_en,
  input  logic                     sample_ready,
  input  logic [ACC_W-1:0]         tw_pend,
  output logic                     sample_valid,
  output logic signed [SAMP_W-1:0] sample_data
);
  localparam int Q   = 1 << QB;
  localparam int AMP = (1 << (SAMP_W - 1)) - 1;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  tw_q;
  logic [ACC_W-1:0]  acc_sum;
  logic              act_q;
  logic              hs;
  logic              flip;
  logic [SAMP_W-2:0] qtab [0:Q];
  logic [QB-1:0]     fine_idx;
  logic [QB:0]       qidx;
  logic [SAMP_W-2:0] mag;

  // Quarter-wave magnitude table, computed at elaboration.
  for (genvar k = 0; k <= Q; k++) begin : g_qtab
    localparam int unsigned V = sine_pt(k, Q, AMP);
    assign qtab[k] = (SAMP_W - 1)'(V);
  end

  assign hs      = act_q && sample_ready;
  assign acc_sum = acc_q + tw_q;
  assign flip    = acc_sum[ACC_W-1] ^ acc_q[ACC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      acc_q <= '0;
      tw_q  <= '0;
    end else if (!tx_en) begin
      act_q <= 1'b0;
      acc_q <= '0;
      tw_q  <= tw_pend;
    end else begin
      act_q <= 1'b1;
      if (hs) begin
        acc_q <= acc_sum;
        if (flip) tw_q <= tw_pend;
      end
    end
  end

  assign fine_idx = acc_q[ACC_W-3 -: QB];
  assign qidx     = acc_q[ACC_W-2] ? ((QB + 1)'(Q) - {1'b0, fine_idx})
                                   : {1'b0, fine_idx};
  assign mag      = qtab[qidx];

  assign sample_valid = act_q;
  assign sample_data  = acc_q[ACC_W-1] ? -$signed({1'b0, mag})
                                       :  $signed({1'b0, mag});

  // R2: a stalled stream keeps its phase.
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && !sample_ready && tx_en |=> $stable(acc_q) && $stable(sample_data));

  // R5: the tone word moves only on a half-cycle crossing.
  p_swap_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && tx_en && !(hs && flip) |=> $stable(tw_q));

  // R10: a fresh start presents phase zero.
  p_start_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q && tx_en |=> act_q && (acc_q == '0));

endmodule

// File: rtl/fsk_dds_mod.sv
`timescale 1ns/1ps
module fsk_dds_mod #(
  parameter int              ACC_W  = 24,
  parameter int              SAMP_W = 10,
  parameter int              QB     = 6,
  parameter longint unsigned CLK_HZ = 16_000_000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tx_en,
  input  logic                     sync_mode,
  input  logic                     zc_sync_en,
  input  logic [2:0]               chan_sel,
  input  logic [1:0]               baud_sel,
  input  logic                     dev_sel,
  input  logic                     txd,
  input  logic                     zc_in,
  output logic                     clr_t,
  output logic signed [SAMP_W-1:0] sample_data,
  output logic                     sample_valid,
  input  logic                     sample_ready
);
  logic             tone_bit;
  logic [ACC_W-1:0] tw_pend;

  fsk_bit_timer #(.CLK_HZ(CLK_HZ)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .sync_mode  (sync_mode),
    .zc_sync_en (zc_sync_en),
    .baud_sel   (baud_sel),
    .txd        (txd),
    .zc_in      (zc_in),
    .clr_t      (clr_t),
    .tone_bit   (tone_bit)
  );

  fsk_tune_sel #(.ACC_W(ACC_W), .CLK_HZ(CLK_HZ)) u_tune (
    .chan_sel (chan_sel),
    .baud_sel (baud_sel),
    .dev_sel  (dev_sel),
    .tone_bit (tone_bit),
    .tw_pend  (tw_pend)
  );

  fsk_dds_core #(.ACC_W(ACC_W), .SAMP_W(SAMP_W), .QB(QB)) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .sample_ready (sample_ready),
    .tw_pend      (tw_pend),
    .sample_valid (sample_valid),
    .sample_data  (sample_data)
  );

  // R1: an idle transmitter offers nothing and drives zero.
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !sample_valid && (sample_data == '0) && !clr_t);

  // R7: the direct mode never toggles the bit clock.
  p_async_no_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !clr_t);

endmodule

// File: tb/fsk_dds_mod_bench.sv
`timescale 1ns/1ps
module fsk_dds_mod_bench;
  localparam int SAMP_W = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       sync_mode = 1'b0;
  logic       zc_sync_en = 1'b0;
  logic [2:0] chan_sel = 3'd0;
  logic [1:0] baud_sel = 2'd3;
  logic       dev_sel = 1'b1;
  logic       txd = 1'b1;
  logic       zc_in = 1'b0;
  logic       sample_ready = 1'b0;
  logic       clr_t;
  logic       sample_valid;
  logic signed [SAMP_W-1:0] sample_data;

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  bit    chk_on = 1'b0;
  string tag = "R1 reset";

  always #10 clk = ~clk; // 50 MHz

  fsk_dds_mod u_fsk_dds_mod (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_en        (tx_en),
    .sync_mode    (sync_mode),
    .zc_sync_en   (zc_sync_en),
    .chan_sel     (chan_sel),
    .baud_sel     (baud_sel),
    .dev_sel      (dev_sel),
    .txd          (txd),
    .zc_in        (zc_in),
    .clr_t        (clr_t),
    .sample_data  (sample_data),
    .sample_valid (sample_valid),
    .sample_ready (sample_ready)
  );

  // ---------------- expected-value functions (from the requirements) -----
  function automatic longint car_f(input int c); // R3
    case (c)
      0: return 60000;  1: return 66000;  2: return 72000;  3: return 76000;
      4: return 82050;  5: return 86000;  6: return 110000; default: return 132500;
    endcase
  endfunction

  function automatic longint hdev_f(input int b, input int d); // R4
    longint baud;
    baud = 600 * (1 << b);
    if (d == 0 && b != 0) return baud / 4;
    return baud / 2;
  endfunction

  function automatic longint rnd_tw(input longint hz);
    return ((hz * 64'd16777216) + 8000000) / 16000000;
  endfunction

  function automatic logic [23:0] exp_tw(input int c, input int b, input int d, input bit one);
    longint ct;
    longint ht;
    ct = rnd_tw(car_f(c));
    ht = rnd_tw(hdev_f(b, d));
    return one ? 24'(ct - ht) : 24'(ct + ht);
  endfunction

  function automatic int per_f(input int b); // R8
    int baud;
    baud = 600 * (1 << b);
    return (16000000 + baud / 2) / baud;
  endfunction

  function automatic int sine_f(input logic [23:0] a); // R6
    int f;
    int i;
    int p;
    int m;
    f = int'(a[21:16]);
    i = a[22] ? 64 - f : f;
    p = i * (128 - i);
    m = (4 * 511 * p) / (20480 - p);
    return a[23] ? -m : m;
  endfunction

  // ---------------- cycle model, stepped at each rising edge -------------
  bit          m_act = 1'b0;
  logic [23:0] m_acc = '0;
  logic [23:0] m_tw = '0;
  int          m_st = 0; // 0 idle, 1 wait, 2 run
  int          m_cnt = 0;
  bit          m_bit = 1'b1;
  bit          m_zcp = 1'b1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 1'b0; m_acc = '0; m_tw = '0; m_st = 0; m_cnt = 0;
      m_bit = 1'b1; m_zcp = 1'b1;
    end else begin
      bit          hs;
      bit          flip;
      bit          zr;
      logic [23:0] sum;
      logic [23:0] pend;
      int          per;
      hs   = m_act && sample_ready;
      sum  = m_acc + m_tw;
      flip = sum[23] ^ m_acc[23];
      pend = exp_tw(int'(chan_sel), int'(baud_sel), int'(dev_sel),
                    sync_mode ? m_bit : txd);
      zr   = zc_in && !m_zcp;
      per  = per_f(int'(baud_sel));
      if (!tx_en) begin
        m_act = 1'b0; m_acc = '0; m_tw = pend; m_st = 0; m_cnt = 0; m_bit = 1'b1;
      end else begin
        m_act = 1'b1;
        if (hs) begin
          m_acc = sum;
          if (flip) m_tw = pend;
        end
        case (m_st)
          0: begin m_st = (sync_mode && zc_sync_en) ? 1 : 2; m_cnt = 0; end
          1: if (zr) m_st = 2;
          default: begin
            if (sync_mode && m_cnt == per / 2 - 1) m_bit = txd;
            m_cnt = (m_cnt >= per - 1) ? 0 : m_cnt + 1;
          end
        endcase
      end
      m_zcp = zc_in;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL [%s] %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Outputs compared away from the active edge.
  always @(negedge clk) begin
    if (chk_on) begin
      int  es;
      bit  ec;
      es = m_act ? sine_f(m_acc) : 0;
      ec = (m_st == 2) && sync_mode && (m_cnt >= per_f(int'(baud_sel)) / 2);
      chk(sample_valid == m_act, "R10/R11 sample_valid", int'(sample_valid), int'(m_act));
      chk(int'(sample_data) == es, "R6/R2/R3 sample_data", int'(sample_data), es);
      chk(clr_t == ec, "R8/R9 clr_t", int'(clr_t), int'(ec));
    end
  end

  task automatic run(input string t, input int n, input int tog, input int rdy);
    tag = t;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      sample_ready = (int'($urandom % 100) < rdy);
      if (tog > 0 && ($urandom % tog) == 0) txd = ~txd;
    end
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7538);
    repeat (2) @(posedge clk);
    #2;
    chk_on = 1'b1;
    run("R1 reset", 3, 0, 100);
    rst_n = 1'b1;
    run("R1 idle", 5, 0, 100);
    tx_en = 1'b1;
    run("R10 start", 300, 0, 100);
    run("R7 async tone follows txd", 2000, 40, 90);
    for (int c = 0; c < 8; c++) begin
      chan_sel = 3'(c);
      run("R3 channel sweep", 1200, 200, 90);
    end
    for (int b = 0; b < 4; b++) begin
      for (int d = 0; d < 2; d++) begin
        baud_sel = 2'(b);
        dev_sel  = d[0];
        run("R4 deviation incl. 600 baud half factor", 700, 100, 95);
      end
    end
    run("R5 tone swap at half cycle", 2000, 5, 70);
    run("R2 stall random", 1500, 60, 20);
    run("R2 stall held", 300, 30, 0);
    tx_en = 1'b0;
    run("R11 stop", 40, 10, 50);
    sync_mode = 1'b1; baud_sel = 2'd3; dev_sel = 1'b1; chan_sel = 3'd5;
    tx_en = 1'b1;
    run("R8 sync bit clock 4800", 12000, 900, 90);
    tx_en = 1'b0;
    run("R11 restart", 5, 0, 50);
    baud_sel = 2'd2;
    tx_en = 1'b1;
    run("R8 sync bit clock 2400", 15000, 1500, 90);
    tx_en = 1'b0; zc_in = 1'b0; zc_sync_en = 1'b1; baud_sel = 2'd3;
    run("R11 restart", 5, 0, 50);
    tx_en = 1'b1;
    run("R9 zero crossing wait", 800, 0, 90);
    zc_in = 1'b1;
    run("R9 zero crossing start", 8000, 700, 90);
    zc_in = 1'b0;
    run("R9 later crossing ignored", 300, 0, 90);
    zc_in = 1'b1;
    run("R9 later crossing ignored", 2000, 0, 90);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL [watchdog] run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule